// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Frame Filtering

This block receives asynchronous serial characters on a single line. A frame-length select chooses between short frames (start bit, eight data bits, stop bit) and long frames (start bit, eight data bits, a ninth data bit, stop bit). The receiver is driven by an external 16x oversampling enable. It confirms a start bit at mid-bit, shifts the data in least significant bit first, and samples the trailing bit(s). After the last bit it decides whether to copy the character into a holding buffer.

A filter control changes meaning with the frame length. With short frames it throws away characters whose stop bit reads low. With long frames it throws away characters whose ninth bit is low, so that on a shared line only address characters wake a listening node. A ready flag marks a held character and raises a one-clock interrupt pulse. Software clears the flag through a clear input. While the flag is set, new characters are dropped and the held one is kept.

Top module: `mp_uart_rx`

## Requirements
- R1: While reset is high and on the clock after it, rx_ready, rx_irq and rx_bit9 are 0 and rx_data is all zeros.
- R2: With frame11=0 and filt_en=0, a frame with stop bit 1 loads its eight data bits (first received bit in rx_data[0]) into rx_data and sets rx_ready.
- R3: With frame11=1 and filt_en=0, an accepted frame loads its data and writes the received ninth bit to rx_bit9, whatever the stop bit value.
- R4: A low level on rxd that has gone high again by the eighth oversampling tick after detection is not a start bit. The outputs do not change, and a following valid frame is received normally.
- R5: If rx_ready is still 1 when a frame completes, rx_data and rx_bit9 keep their earlier values and no interrupt pulse is produced.
- R6: With frame11=0 and filt_en=1, a frame whose stop bit is 0 is discarded, and a frame whose stop bit is 1 is accepted.
- R7: With frame11=0, an accepted frame writes its received stop bit value to rx_bit9; with filt_en=0 a stop bit of 0 is accepted and gives rx_bit9=0.
- R8: With frame11=1 and filt_en=1, a frame whose ninth bit is 0 is discarded, and a frame whose ninth bit is 1 is loaded and sets rx_ready.
- R9: rx_irq is high for exactly one clock, in the cycle that rx_ready rises. rx_ready then stays 1 until ready_clr is asserted.
- R10: A one-clock ready_clr pulse makes rx_ready 0 on the next clock.
- R11: Bit timing counts only clocks where os_tick is high, so a tick at every second clock receives frames at half the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Enable at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| frame11 | input | 1 | 0: ten-bit frames, 1: eleven-bit frames |
| filt_en | input | 1 | Discard filter enable |
| ready_clr | input | 1 | Clears the ready flag |
| rx_data | output | DW | Receive holding buffer |
| rx_ready | output | 1 | Character held |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the held character |
| rx_irq | output | 1 | One-clock pulse when rx_ready rises |

## Verification
A wrong bit counter or sample phase shows up as shifted or corrupted data. It also appears as a wrong rx_bit9, because in this block the ninth-bit and stop positions sit right next to the data. The error reaches the ports within a clock of the end of the frame. A wrong filter or overrun decision shows up as an extra or missing interrupt, or as a buffer that changes when it should not. The bench models these outcomes from the requirements and compares rx_ready, rx_data and rx_bit9 on every clock once a frame or clear has settled. A start detector that leaves idle on a glitch and stays out of step corrupts the next frame, so the frame after a glitch is checked too.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  // Acceptance rule: filter looks at stop bit (10-bit) or ninth bit (11-bit)
  function automatic logic frame_passes(input logic long_frame, input logic filt,
                                        input logic ninth, input logic stop);
    if (!filt) return 1'b1;
    return long_frame ? ninth : stop;
  endfunction
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mprx_shift.sv
module mprx_shift
  import mprx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line,
  input  logic          frame11,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DW + 2);

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  last_idx;

  assign last_idx = frame11 ? IW'(DW + 1) : IW'(DW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
      data  <= '0;
      ninth <= 1'b0;
      stop  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (!line) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              st  <= line ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              idx <= idx + 1'b1;
              if (idx < IW'(DW)) begin
                data <= {line, data[DW-1:1]};
              end else if (idx == last_idx) begin
                stop <= line;
                done <= 1'b1;
                st   <= RX_IDLE;
              end else begin
                ninth <= line;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mprx_accept.sv
module mprx_accept
  import mprx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] data,
  input  logic          ninth,
  input  logic          stop,
  input  logic          frame11,
  input  logic          filt_en,
  input  logic          ready_clr,
  output logic [DW-1:0] hold,
  output logic          ready,
  output logic          bit9,
  output logic          irq
);
  logic take;

  assign take = done && !ready && frame_passes(frame11, filt_en, ninth, stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      ready <= 1'b0;
      bit9  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ready_clr) ready <= 1'b0;
      if (take) begin
        hold  <= data;
        bit9  <= frame11 ? ninth : stop;
        ready <= 1'b1;
        irq   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          frame11,
  input  logic          filt_en,
  input  logic          ready_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_bit9,
  output logic          rx_irq
);
  logic          line_s;
  logic          frame_done;
  logic [DW-1:0] sh_data;
  logic          sh_ninth;
  logic          sh_stop;

  mprx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  mprx_shift #(.OVS(OVS), .DW(DW)) u_shift (
    .clk(clk), .rst(rst), .tick(os_tick), .line(line_s), .frame11(frame11),
    .done(frame_done), .data(sh_data), .ninth(sh_ninth), .stop(sh_stop)
  );

  mprx_accept #(.DW(DW)) u_accept (
    .clk(clk), .rst(rst), .done(frame_done), .data(sh_data), .ninth(sh_ninth),
    .stop(sh_stop), .frame11(frame11), .filt_en(filt_en), .ready_clr(ready_clr),
    .hold(rx_data), .ready(rx_ready), .bit9(rx_bit9), .irq(rx_irq)
  );
endmodule

// File: rtl/mprx_check.sv
module mprx_check #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ready_clr,
  input logic          frame_done,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          rx_bit9,
  input logic          rx_irq
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!rx_ready && !rx_irq && !rx_bit9 && rx_data == '0));

  // R9
  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R9
  a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_ready && !$past(rx_ready)));

  // R9
  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !ready_clr) |=> rx_ready);

  // R10
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    ready_clr |=> !rx_ready);

  // R5
  a_r5_overrun_hold: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> ($stable(rx_data) && $stable(rx_bit9)));

  // R2
  a_r2_load_only_at_end: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data));
endmodule

bind mp_uart_rx mprx_check #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ready_clr(ready_clr), .frame_done(frame_done),
  .rx_data(rx_data), .rx_ready(rx_ready), .rx_bit9(rx_bit9), .rx_irq(rx_irq)
);

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          os_tick = 1'b0;
  logic          rxd = 1'b1;
  logic          frame11 = 1'b0;
  logic          filt_en = 1'b0;
  logic          ready_clr = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_ready;
  logic          rx_bit9;
  logic          rx_irq;

  mp_uart_rx #(.OVS(16), .DW(DW)) uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .frame11(frame11),
    .filt_en(filt_en), .ready_clr(ready_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_bit9(rx_bit9), .rx_irq(rx_irq)
  );

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tcnt = 0;
  int irq_seen = 0;
  bit settled = 1'b0;
  bit done_flag = 1'b0;

  // behavioural reference state
  logic          exp_ready = 1'b0;
  logic [DW-1:0] exp_data = '0;
  logic          exp_b9 = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin os_tick = 1'b1; tcnt = 0; end
    else begin os_tick = 1'b0; tcnt = tcnt + 1; end
  end

  // clock-by-clock comparison with the model
  always @(negedge clk) begin
    if (rx_irq) irq_seen++;
    if (settled && !rst) begin
      check("R9", "ready", 32'(rx_ready), 32'(exp_ready));
      check("R5", "data", 32'(rx_data), 32'(exp_data));
      check("R7", "bit9", 32'(rx_bit9), 32'(exp_b9));
    end
  end

  task automatic send_frame(input string req, input bit f11, input bit filt,
                            input logic [DW-1:0] d, input bit b9, input bit stp);
    int bitclk;
    bit acc;
    int exp_irq;
    bitclk = 16 * tick_div;
    settled = 1'b0;
    frame11 = f11;
    filt_en = filt;
    irq_seen = 0;
    rxd = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      rxd = d[i];
      repeat (bitclk) @(negedge clk);
    end
    if (f11) begin
      rxd = b9;
      repeat (bitclk) @(negedge clk);
    end
    rxd = stp;
    repeat (bitclk) @(negedge clk);
    rxd = 1'b1;
    repeat (24 * tick_div) @(negedge clk);
    acc = !filt || (f11 ? b9 : stp);
    exp_irq = 0;
    if (acc && !exp_ready) begin
      exp_data = d;
      exp_b9 = f11 ? b9 : stp;
      exp_ready = 1'b1;
      exp_irq = 1;
    end
    check(req, "ready after frame", 32'(rx_ready), 32'(exp_ready));
    check(req, "data after frame", 32'(rx_data), 32'(exp_data));
    check(req, "bit9 after frame", 32'(rx_bit9), 32'(exp_b9));
    check("R9", "irq pulses", 32'(irq_seen), 32'(exp_irq));
    settled = 1'b1;
  endtask

  task automatic clear_ready();
    settled = 1'b0;
    ready_clr = 1'b1;
    @(negedge clk);
    ready_clr = 1'b0;
    exp_ready = 1'b0;
    check("R10", "ready after clear", 32'(rx_ready), 32'(0));
    @(negedge clk);
    settled = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "ready in reset", 32'(rx_ready), 32'(0));
    check("R1", "data in reset", 32'(rx_data), 32'(0));
    check("R1", "irq in reset", 32'(rx_irq), 32'(0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "bit9 after reset", 32'(rx_bit9), 32'(0));
    settled = 1'b1;
    repeat (10) @(negedge clk);

    send_frame("R2", 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1);
    repeat (40) @(negedge clk);        // R9: ready held (per-clock compare)
    clear_ready();
    send_frame("R7", 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0);
    clear_ready();
    send_frame("R6", 1'b0, 1'b1, 8'h11, 1'b0, 1'b0);
    send_frame("R6", 1'b0, 1'b1, 8'h81, 1'b0, 1'b1);
    send_frame("R5", 1'b0, 1'b0, 8'h55, 1'b0, 1'b1);
    clear_ready();
    send_frame("R3", 1'b1, 1'b0, 8'hC3, 1'b0, 1'b0);
    clear_ready();
    send_frame("R8", 1'b1, 1'b1, 8'h22, 1'b0, 1'b1);
    send_frame("R8", 1'b1, 1'b1, 8'h7E, 1'b1, 1'b1);
    clear_ready();

    // R4: short low pulse must not start a frame
    irq_seen = 0;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R4", "ready after glitch", 32'(rx_ready), 32'(0));
    check("R4", "irq after glitch", 32'(irq_seen), 32'(0));
    send_frame("R4", 1'b0, 1'b0, 8'h0F, 1'b0, 1'b1);
    clear_ready();

    // R11: tick at every second clock
    tick_div = 2;
    repeat (4) @(negedge clk);
    send_frame("R11", 1'b1, 1'b0, 8'h96, 1'b1, 1'b1);

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule